// File: doc/BRIEF.md
# Write-Guarded Channel Service Request Register

This block holds a service request code for each of several channels in one shared register. Two kinds of writer change it. A host processor posts requests. Each channel engine retires its own request once the service is done. The register is guarded against the host: a code of zero in any field of a host write is dropped. Only the channel engine may return a field to zero, which marks it as complete.

Because of this rule, the host can post a request for one channel with a single plain write, putting zeros in every other field. It does not need to read the register first, and it cannot wipe out a request that another channel still has pending. Byte strobes limit a host write further, to the enabled byte lanes. Each channel has a completion strobe input, and each channel drives a pending output that stays high while its field holds a request. Choosing which pending channel is served next is handled elsewhere.

Top module: `svcreq_guard_reg`

## Requirements
- R1: After reset, every field reads 00 and every pending output is low.
- R2: At the clock edge of a host write, a field whose byte strobe is set and whose written code is non-zero (01 requests channel initialisation; 10 and 11 are further requests) takes the written code.
- R3: A field written by the host as 00 keeps its previous code. This also applies when no host write is enabled.
- R4: A field in a byte lane whose strobe is clear keeps its code whatever data is written. Byte lane k covers data bits 8k+7:8k.
- R5: At the clock edge where a channel's completion strobe is high, that channel's field becomes 00, provided the host is not writing a request to it in that cycle.
- R6: When a non-zero host write and the completion strobe hit the same field in the same cycle, the field takes the host code.
- R7: A channel's pending output is high exactly when its field is non-zero.
- R8: The read port shows the register with channel i in bits 2i+1:2i. Channel 0 is in bits 1:0.
- R9: A single host write of 0x0001 with all strobes set requests initialisation of channel 0 and leaves channels 1 to 7 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write enable |
| wr_data | input | 16 | Host write data, one 2-bit code per channel |
| wr_strb | input | 2 | Host byte-lane strobes |
| rd_data | output | 16 | Current register contents |
| done | input | 8 | Per-channel service completion strobes |
| pending | output | 8 | Per-channel request-pending flags |

## Verification
The bench uses the default parameters: eight channels, 2-bit codes and two byte lanes. With these values, four fields sit in each byte lane. A single strobe can therefore mask half the channels while the other half still update, which exercises lane masking and the zero guard together. Completion strobes are applied alone, together with overlapping host writes on every channel at once, and alongside writes masked to the opposite lane, so that each precedence case appears.

// File: rtl/svcreq_pkg.sv
package svcreq_pkg;
  // Byte lane holding field idx for the given code width.
  function automatic int field_lane(int idx, int code_w);
    return (idx * code_w) / 8;
  endfunction

  // A code counts as a request when it is non-zero.
  function automatic logic is_request(logic [7:0] code);
    return |code;
  endfunction
endpackage

// File: rtl/svcreq_lane_decode.sv
module svcreq_lane_decode #(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 2,
  localparam int REG_W  = NUM_CH * CODE_W,
  localparam int BYTE_N = (REG_W + 7) / 8
) (
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [BYTE_N-1:0] wr_strb,
  output logic [NUM_CH-1:0] host_take
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int LANE = svcreq_pkg::field_lane(i, CODE_W);
    logic [7:0] code_ext;
    always_comb begin
      code_ext = '0;
      code_ext[CODE_W-1:0] = wr_data[i*CODE_W +: CODE_W];
    end
    assign host_take[i] = wr_en & wr_strb[LANE] & svcreq_pkg::is_request(code_ext);
  end
endmodule

// File: rtl/svcreq_field.sv
module svcreq_field #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_take,
  input  logic [CODE_W-1:0] host_code,
  input  logic              done,
  output logic [CODE_W-1:0] code_q,
  output logic              pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         code_q <= '0;
    else if (host_take) code_q <= host_code;
    else if (done)      code_q <= '0;
  end
  assign pend = |code_q;
endmodule

// File: rtl/svcreq_guard_reg.sv
module svcreq_guard_reg #(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 2,
  localparam int REG_W  = NUM_CH * CODE_W,
  localparam int BYTE_N = (REG_W + 7) / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [BYTE_N-1:0] wr_strb,
  output logic [REG_W-1:0]  rd_data,
  input  logic [NUM_CH-1:0] done,
  output logic [NUM_CH-1:0] pending
);
  // Named internal events, also used by the checker.
  logic [NUM_CH-1:0] host_take;
  logic [NUM_CH-1:0] clr_take;

  svcreq_lane_decode #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_dec (
    .wr_en(wr_en), .wr_data(wr_data), .wr_strb(wr_strb), .host_take(host_take)
  );

  assign clr_take = done & ~host_take;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_fld
    svcreq_field #(.CODE_W(CODE_W)) u_fld (
      .clk(clk), .rst_n(rst_n),
      .host_take(host_take[i]),
      .host_code(wr_data[i*CODE_W +: CODE_W]),
      .done(done[i]),
      .code_q(rd_data[i*CODE_W +: CODE_W]),
      .pend(pending[i])
    );
  end
endmodule

// File: rtl/svcreq_guard_chk.sv
module svcreq_guard_chk #(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 2,
  localparam int REG_W  = NUM_CH * CODE_W,
  localparam int BYTE_N = (REG_W + 7) / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [REG_W-1:0]  wr_data,
  input logic [BYTE_N-1:0] wr_strb,
  input logic [REG_W-1:0]  rd_data,
  input logic [NUM_CH-1:0] done,
  input logic [NUM_CH-1:0] pending,
  input logic [NUM_CH-1:0] host_take,
  input logic [NUM_CH-1:0] clr_take
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    assert_host_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      host_take[i] |=> rd_data[i*CODE_W +: CODE_W] == $past(wr_data[i*CODE_W +: CODE_W]));
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_take[i] && !done[i]) |=> $stable(rd_data[i*CODE_W +: CODE_W]));
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_take[i] |=> rd_data[i*CODE_W +: CODE_W] == '0);
    assert_host_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_take[i] && done[i]) |=> rd_data[i*CODE_W +: CODE_W] != '0);
    assert_pend_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending[i]) |-> $past(host_take[i]));
  end
endmodule

bind svcreq_guard_reg svcreq_guard_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_strb(wr_strb),
  .rd_data(rd_data), .done(done), .pending(pending),
  .host_take(host_take), .clr_take(clr_take)
);

// File: tb/svcreq_guard_reg_tb.sv
`timescale 1ns/1ps
module svcreq_guard_reg_tb;
  localparam int NCH = 8;

  typedef struct {
    logic [15:0] val;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  wr_strb = '0;
  logic [7:0]  done = '0;
  logic [15:0] rd_data;
  logic [7:0]  pending;

  int checks = 0;
  int fails = 0;
  logic [15:0] model = '0;
  exp_t q[$];

  always #2 clk = ~clk;

  svcreq_guard_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_data(rd_data), .done(done), .pending(pending)
  );

  function automatic logic [7:0] pend_of(logic [15:0] v);
    logic [7:0] p;
    for (int c = 0; c < NCH; c++) p[c] = (v[2*c +: 2] != 2'b00);
    return p;
  endfunction

  task automatic check(logic [15:0] exp, string tag);
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s rd_data (R8) actual=%h expected=%h", tag, rd_data, exp);
    end
    checks++;
    if (pending !== pend_of(exp)) begin
      fails++;
      $display("FAIL %s pending (R7) actual=%b expected=%b", tag, pending, pend_of(exp));
    end
  endtask

  // Driver: applies one cycle of stimulus, updates the model, and queues the result.
  task automatic drive(logic we, logic [15:0] d, logic [1:0] s, logic [7:0] dn, string tag);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_data = d; wr_strb = s; done = dn;
    for (int c = 0; c < NCH; c++) begin
      if (we && s[c/4] && d[2*c +: 2] != 2'b00) model[2*c +: 2] = d[2*c +: 2];
      else if (dn[c])                          model[2*c +: 2] = 2'b00;
    end
    e.val = model; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares each queued result just after the edge that produces it.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.val, e.tag);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all R) actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(16'h0000, "R1 reset");
    rst_n = 1'b1;
    drive(1, 16'h0001, 2'b11, 8'h00, "R9 single ch0 init");
    drive(1, 16'h00E4, 2'b11, 8'h00, "R2 ch1..3 codes");
    drive(1, 16'h0000, 2'b11, 8'h00, "R3 all-zero write");
    drive(1, 16'hFF00, 2'b01, 8'h00, "R4 upper lane masked");
    drive(1, 16'hFF00, 2'b10, 8'h00, "R2 upper lane write");
    drive(1, 16'h0008, 2'b11, 8'h00, "R3 overwrite ch1 only");
    drive(0, 16'h0000, 2'b00, 8'h08, "R5 clear ch3");
    drive(1, 16'h0002, 2'b11, 8'h01, "R6 collide ch0");
    drive(0, 16'hFFFF, 2'b11, 8'hFF, "R5 clear all");
    drive(0, 16'hFFFF, 2'b11, 8'h00, "R3 write disabled");
    drive(1, 16'h5555, 2'b11, 8'hAA, "R6 collide all");
    drive(1, 16'h0000, 2'b10, 8'h0F, "R5 clear with masked zero write");
    drive(1, 16'hC000, 2'b01, 8'h00, "R4 lower lane only zero");
    drive(0, 16'h0000, 2'b00, 8'h00, "R3 idle hold");
    wait (q.size() == 0);
    @(negedge clk);
    rst_n = 1'b0;
    model = '0;
    #1;
    check(16'h0000, "R1 reset mid-run");
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule